// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block is the interrupt logic of a UART whose register set follows the long-established serial controller layout. Five interrupt sources are each latched into a pending flag from a one-cycle set pulse. The sources are receiver line status error, received data available, character timeout, transmit holding register empty and modem status change. Each flag is cleared as a side effect of the register access that services it.

The enabled pending sources are ranked by a fixed priority and encoded into the identification byte. The unit also drives a single request pin, which the modem-control gating bit must allow. The interrupt enable register and the gating bit are written over the same 3-bit address bus that carries the read strobes the unit snoops.

Serial shifting, FIFO storage and baud generation sit outside this block. It only sees their one-cycle event pulses and a FIFO-enabled level.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the enable bits, the gating bit and all pending flags are zero, `iid_o` reads 0x01 and `irq_o` is low.
- R2: A write to address 1 loads the enables. Bit 0 enables data-available and timeout, bit 1 transmit-empty, bit 2 line status and bit 3 modem status. A write to address 4 loads the gating bit from data bit 3. A pending source whose enable is clear is not reported.
- R3: `iid_o[0]` is 1 when no enabled source is pending. Otherwise `iid_o[3:0]` is 6 for line status, 4 for data available, 12 for timeout, 2 for transmit empty and 0 for modem status. Bits 5:4 are always 0.
- R4: `iid_o[7:6]` read 2'b11 while `fifo_en_i` is high and 2'b00 while it is low, in the same cycle.
- R5: Priority from highest to lowest is line status, then data available, then timeout, then transmit empty, then modem status.
- R6: A read at address 5 clears the line status flag.
- R7: A read at address 0 clears both the data-available and the timeout flags.
- R8: A read at address 2 clears the transmit-empty flag only when `iid_o[3:0]` reports 2 in that cycle. A write at address 0 also clears it. An address 2 read that reports another code leaves it pending.
- R9: A read at address 6 clears the modem status flag.
- R10: `irq_o` is high exactly when some enabled source is pending and the gating bit is set. It changes on the same clock edge as the state it depends on, with no added register.
- R11: Flags latch whether or not they are enabled, and are reported once enabled. A set pulse wins over a clearing access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| fifo_en_i | input | 1 | FIFOs enabled level |
| ls_set_i | input | 1 | Receiver line status error event |
| rda_set_i | input | 1 | Received data available event |
| tmo_set_i | input | 1 | Character timeout event |
| thre_set_i | input | 1 | Transmit holding register empty event |
| ms_set_i | input | 1 | Modem status change event |
| iid_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request pin |

## Verification
The assertions assume that `rd_i` and `wr_i` are never high together and that each strobe marks one access lasting one cycle. They also assume set pulses come from the datapath, independent of the bus. The stimulus never raises both strobes at once. It drives every input just after the rising edge, so the pulse and access combinations that R8 and R11 depend on are presented whole for one edge. The random phase mixes set pulses with accesses to every address, including ones the unit ignores.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC  = 5;
  localparam int SRC_LS   = 0;
  localparam int SRC_RDA  = 1;
  localparam int SRC_TMO  = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MS   = 4;

  localparam int ADR_DATA = 0;
  localparam int ADR_IER  = 1;
  localparam int ADR_IID  = 2;
  localparam int ADR_MCR  = 4;
  localparam int ADR_LSR  = 5;
  localparam int ADR_MSR  = 6;

  localparam int ENA_W    = 4;
  localparam int GATE_BIT = 3;

  typedef enum logic [3:0] {
    IID_MSR  = 4'h0,
    IID_NONE = 4'h1,
    IID_THRE = 4'h2,
    IID_RDA  = 4'h4,
    IID_LSR  = 4'h6,
    IID_TMO  = 4'hC
  } iid_e;
endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ENA_W-1:0]  ena_o,
  output logic              gate_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_o  <= '0;
      gate_o <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(ADR_IER)) ena_o  <= wdata_i[ENA_W-1:0];
      if (addr_i == ADDR_W'(ADR_MCR)) gate_o <= wdata_i[GATE_BIT];
    end
  end

  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_W'(ADR_MCR)) |=> $stable(gate_o)) else $error("gate changed"); // R2
endmodule

// File: rtl/uart_irq_pend.sv
module uart_irq_pend #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_o[g] <= 1'b0;
      else if (set_i[g])  pend_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g])  pend_o[g] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> pend_o[g]) else $error("set lost"); // R11
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] act_i,
  input  logic               fifo_en_i,
  output iid_e               code_o,
  output logic [7:0]         iid_o
);
  always_comb begin
    if      (act_i[SRC_LS])   code_o = IID_LSR;
    else if (act_i[SRC_RDA])  code_o = IID_RDA;
    else if (act_i[SRC_TMO])  code_o = IID_TMO;
    else if (act_i[SRC_THRE]) code_o = IID_THRE;
    else if (act_i[SRC_MS])   code_o = IID_MSR;
    else                      code_o = IID_NONE;
  end

  assign iid_o = {{2{fifo_en_i}}, 2'b00, code_o};
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fifo_en_i,
  input  logic              ls_set_i,
  input  logic              rda_set_i,
  input  logic              tmo_set_i,
  input  logic              thre_set_i,
  input  logic              ms_set_i,
  output logic [7:0]        iid_o,
  output logic              irq_o
);
  logic [ENA_W-1:0]   ena;
  logic               gate;
  logic [NUM_SRC-1:0] set_v, clr_v, pend, src_en, act;
  iid_e               code;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int r);
    return a == ADDR_W'(r);
  endfunction

  uart_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ena_o(ena), .gate_o(gate)
  );

  always_comb begin
    set_v = '0;
    set_v[SRC_LS]   = ls_set_i;
    set_v[SRC_RDA]  = rda_set_i;
    set_v[SRC_TMO]  = tmo_set_i;
    set_v[SRC_THRE] = thre_set_i;
    set_v[SRC_MS]   = ms_set_i;

    clr_v = '0;
    clr_v[SRC_LS]   = rd_i && hit(addr_i, ADR_LSR);
    clr_v[SRC_RDA]  = rd_i && hit(addr_i, ADR_DATA);
    clr_v[SRC_TMO]  = rd_i && hit(addr_i, ADR_DATA);
    // identification read only acknowledges THRE when it is what the read returns
    clr_v[SRC_THRE] = (rd_i && hit(addr_i, ADR_IID) && code == IID_THRE) ||
                      (wr_i && hit(addr_i, ADR_DATA));
    clr_v[SRC_MS]   = rd_i && hit(addr_i, ADR_MSR);

    src_en = '0;
    src_en[SRC_LS]   = ena[2];
    src_en[SRC_RDA]  = ena[0];
    src_en[SRC_TMO]  = ena[0];
    src_en[SRC_THRE] = ena[1];
    src_en[SRC_MS]   = ena[3];
  end

  uart_irq_pend #(.N(NUM_SRC)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v), .clr_i(clr_v), .pend_o(pend)
  );

  assign act = pend & src_en;

  uart_irq_prio u_prio (
    .act_i(act), .fifo_en_i(fifo_en_i), .code_o(code), .iid_o(iid_o)
  );

  assign irq_o = gate && (|act);

  AST_IRQ_HAS_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !iid_o[0]) else $error("irq without id"); // R10
  AST_LS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit(addr_i, ADR_LSR) && !ls_set_i) |=> iid_o[3:0] != IID_LSR) else $error("ls kept"); // R6
  AST_MS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit(addr_i, ADR_MSR) && !ms_set_i) |=> iid_o[3:0] != IID_MSR) else $error("ms kept"); // R9
  AST_THRE_WR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit(addr_i, ADR_DATA) && !thre_set_i) |=> iid_o[3:0] != IID_THRE) else $error("thre kept"); // R8
  AST_RD_DATA_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit(addr_i, ADR_DATA) && !rda_set_i && !tmo_set_i) |=>
      (iid_o[3:0] != IID_RDA && iid_o[3:0] != IID_TMO)) else $error("rx kept"); // R7
endmodule

// File: tb/uart_irq_id_tb.sv
module uart_irq_id_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0, fifo_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [4:0] setv = '0;   // 0 ls, 1 rda, 2 tmo, 3 thre, 4 ms
  logic [7:0] iid;
  logic       irq;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";

  // reference state
  bit m_ls, m_rda, m_tmo, m_thre, m_ms, m_gate;
  bit [3:0] m_ena;

  always #4 clk = ~clk;

  uart_irq_id u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .fifo_en_i(fifo_en), .ls_set_i(setv[0]), .rda_set_i(setv[1]),
    .tmo_set_i(setv[2]), .thre_set_i(setv[3]), .ms_set_i(setv[4]),
    .iid_o(iid), .irq_o(irq)
  );

  function automatic int m_code();
    if (m_ena[2] && m_ls)   return 6;
    if (m_ena[0] && m_rda)  return 4;
    if (m_ena[0] && m_tmo)  return 12;
    if (m_ena[1] && m_thre) return 2;
    if (m_ena[3] && m_ms)   return 0;
    return 1;
  endfunction

  function automatic logic [7:0] m_iid();
    return {fifo_en ? 2'b11 : 2'b00, 2'b00, 4'(m_code())};
  endfunction

  function automatic bit m_irq();
    return m_gate && (m_code() != 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_ls, m_rda, m_tmo, m_thre, m_ms, m_gate} = '0;
      m_ena = '0;
    end else begin
      int c;
      c = m_code();
      if (rd && addr == 5) m_ls = 0;
      if (rd && addr == 0) begin m_rda = 0; m_tmo = 0; end
      if ((rd && addr == 2 && c == 2) || (wr && addr == 0)) m_thre = 0;
      if (rd && addr == 6) m_ms = 0;
      if (setv[0]) m_ls = 1;
      if (setv[1]) m_rda = 1;
      if (setv[2]) m_tmo = 1;
      if (setv[3]) m_thre = 1;
      if (setv[4]) m_ms = 1;
      if (wr && addr == 1) m_ena = wdata[3:0];
      if (wr && addr == 4) m_gate = wdata[3];
    end
  end

  task automatic chk(input string req, input logic [7:0] a_iid, input logic a_irq,
                     input logic [7:0] e_iid, input logic e_irq);
    compared++;
    if (a_iid !== e_iid || a_irq !== e_irq) begin
      mismatched++;
      $display("FAIL %s: iid=%02h irq=%b expected iid=%02h irq=%b", req, a_iid, a_irq, e_iid, e_irq);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) chk(cur_req, iid, irq, m_iid(), m_irq());

  task automatic drive(input logic [4:0] s, input logic r, input logic w,
                       input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    setv = s; rd = r; wr = w; addr = a; wdata = d;
  endtask

  task automatic pulse(input logic [4:0] s, input logic r, input logic w,
                       input logic [2:0] a, input logic [7:0] d);
    drive(s, r, w, a, d);
    drive('0, 1'b0, 1'b0, 3'd7, 8'h00);
  endtask

  task automatic expect_now(input string req, input logic [7:0] e_iid, input logic e_irq);
    @(negedge clk); #1;
    chk(req, iid, irq, e_iid, e_irq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    expect_now("R1", 8'h01, 1'b0);

    cur_req = "R2";
    pulse('0, 0, 1, 3'd1, 8'h02);            // transmit-empty only
    pulse('0, 0, 1, 3'd4, 8'h08);            // gate on
    pulse(5'b01000, 0, 0, 3'd7, 8'h00);
    expect_now("R2", 8'h02, 1'b1);
    pulse(5'b00010, 0, 0, 3'd7, 8'h00);      // data-available, not enabled
    expect_now("R2", 8'h02, 1'b1);

    cur_req = "R11";
    pulse('0, 0, 1, 3'd1, 8'h0F);
    expect_now("R11", 8'h04, 1'b1);

    cur_req = "R4";
    drive('0, 0, 0, 3'd7, 8'h00); fifo_en = 1'b1;
    expect_now("R4", 8'hC4, 1'b1);

    cur_req = "R7";
    pulse('0, 1, 0, 3'd0, 8'h00);
    expect_now("R7", 8'hC2, 1'b1);
    drive('0, 0, 0, 3'd7, 8'h00); fifo_en = 1'b0;

    cur_req = "R8";
    pulse(5'b10000, 0, 0, 3'd7, 8'h00);
    pulse('0, 1, 0, 3'd2, 8'h00);            // id read reporting 2
    expect_now("R8", 8'h00, 1'b1);
    cur_req = "R9";
    pulse('0, 1, 0, 3'd6, 8'h00);
    expect_now("R9", 8'h01, 1'b0);

    cur_req = "R5";
    pulse(5'b11111, 0, 0, 3'd7, 8'h00);
    expect_now("R5", 8'h06, 1'b1);
    cur_req = "R6";
    pulse('0, 1, 0, 3'd5, 8'h00);
    expect_now("R6", 8'h04, 1'b1);
    cur_req = "R7";
    pulse('0, 1, 0, 3'd0, 8'h00);
    expect_now("R7", 8'h02, 1'b1);
    cur_req = "R5";
    pulse('0, 1, 0, 3'd2, 8'h00);
    expect_now("R5", 8'h00, 1'b1);
    pulse('0, 1, 0, 3'd6, 8'h00);
    expect_now("R9", 8'h01, 1'b0);

    cur_req = "R3";
    pulse(5'b00100, 0, 0, 3'd7, 8'h00);
    expect_now("R3", 8'h0C, 1'b1);
    pulse('0, 1, 0, 3'd0, 8'h00);
    expect_now("R3", 8'h01, 1'b0);

    cur_req = "R8";
    pulse(5'b01001, 0, 0, 3'd7, 8'h00);
    pulse('0, 1, 0, 3'd2, 8'h00);            // reports 6, must not clear THRE
    pulse('0, 1, 0, 3'd5, 8'h00);
    expect_now("R8", 8'h02, 1'b1);
    pulse('0, 0, 1, 3'd0, 8'h55);
    expect_now("R8", 8'h01, 1'b0);

    cur_req = "R10";
    pulse(5'b10000, 0, 0, 3'd7, 8'h00);
    expect_now("R10", 8'h00, 1'b1);
    pulse('0, 0, 1, 3'd4, 8'h00);
    expect_now("R10", 8'h00, 1'b0);
    pulse('0, 0, 1, 3'd4, 8'h08);
    expect_now("R10", 8'h00, 1'b1);
    pulse('0, 1, 0, 3'd6, 8'h00);

    cur_req = "R11";
    pulse(5'b00001, 1, 0, 3'd5, 8'h00);      // set and clear together
    expect_now("R11", 8'h06, 1'b1);
    pulse('0, 1, 0, 3'd5, 8'h00);
    expect_now("R11", 8'h01, 1'b0);

    cur_req = "R2/R5/R10 random";
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] s;
      logic r, w;
      logic [2:0] a;
      s = '0;
      for (int b = 0; b < 5; b++) s[b] = ($urandom_range(0, 9) == 0);
      r = ($urandom_range(0, 2) == 0);
      w = !r && ($urandom_range(0, 5) == 0);
      a = 3'($urandom_range(0, 7));
      drive(s, r, w, a, 8'($urandom));
      if ($urandom_range(0, 31) == 0) fifo_en = ~fifo_en;
    end
    drive('0, 0, 0, 3'd7, 8'h00);
    @(negedge clk); #1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule